// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns a single block-transfer request into a sequence of single-word memory accesses. A request carries a base address, a 16-bit mask that selects registers, a load/store direction, one of four walk modes (increment-after, increment-before, decrement-after, decrement-before), and a flag that asks for the moved base to be returned. Stack-style requests can name a stack flavour instead: full or empty, ascending or descending. The sequencer maps that flavour to one of the walk modes, and the mapping depends on whether the request is a push (store) or a pop (load).

Each access carries a register index, a word address and a write strobe. The access is held until the memory raises its ready signal, so the memory sets the time per access. Registers always go out in ascending index order, and the lowest index always lands at the lowest address in every mode. After the last access is accepted, a one-cycle done pulse is raised. When writeback was requested, the final base is valid in that same cycle. A request of N registers occupies N accepted accesses plus two cycles: one to take the request and one for the done pulse.

Top module: `blk_xfer_seq`

## Requirements
- R1: Mode code 0 (increment-after) accesses base, base+4, base+8, and so on, one word per selected register.
- R2: Mode code 1 (increment-before) starts at base+4 and steps up by 4.
- R3: Mode code 2 (decrement-after) uses the window that ends at base, so the first access is at base−4·N+4.
- R4: Mode code 3 (decrement-before) uses the window that ends at base−4, so the first access is at base−4·N.
- R5: Mask bit i selects register i. Registers are issued in ascending index order, one per accepted access, at consecutive word addresses. mem_we is 1 for a store (is_load=0) and 0 for a load.
- R6: When writeback=1, wb_valid is high together with done, and wb_addr is base+4·N for modes 0 and 1, or base−4·N for modes 2 and 3. When writeback=0, wb_valid stays low.
- R7: With stack_en=1 and is_load=0, stack_kind selects the mode as follows: 0 (full-ascending) → 1, 1 (full-descending) → 3, 2 (empty-ascending) → 0, 3 (empty-descending) → 2.
- R8: With stack_en=1 and is_load=1, stack_kind selects the mode as follows: 0 → 2, 1 → 0, 2 → 3, 3 → 1.
- R9: An all-zero mask makes no memory access, and done is raised in the cycle after the request.
- R10: While mem_req is high and mem_ready is low, mem_addr and mem_reg stay unchanged.
- R11: A start pulse that arrives while busy is high has no effect on the sequence in progress.
- R12: done is high for exactly one cycle, in the cycle after the last access is accepted. After that cycle, busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only while idle |
| base_addr | input | AW | Base address of the transfer |
| reg_list | input | NR | Register selection mask |
| is_load | input | 1 | 1 = load (pop), 0 = store (push) |
| addr_mode | input | 2 | Walk mode: 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| stack_en | input | 1 | Use stack_kind in place of addr_mode |
| stack_kind | input | 2 | 0 full-asc, 1 full-desc, 2 empty-asc, 3 empty-desc |
| writeback | input | 1 | Return the moved base at the end |
| busy | output | 1 | A request is in progress |
| mem_req | output | 1 | Access valid |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address of the access |
| mem_reg | output | $clog2(NR) | Register index of the access |
| mem_ready | input | 1 | Memory accepts the current access |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | wb_addr holds the new base |
| wb_addr | output | AW | Moved base address |

## Verification
The test sweeps every walk mode in both directions, with and without writeback. Each combination runs against a set of masks:
- empty, which separates the no-access path from the normal path;
- a single bit at either end, which exposes first-address off-by-one errors between the before and after variants;
- contiguous and sparse masks, which show whether registers are skipped or reordered;
- the full mask, which checks the widest address span.

A fixed stall pattern on mem_ready tells holding an access apart from advancing early. One run pulses start in the middle of a sequence. Every stack flavour is also applied as a push and as a pop, and known stack-pointer results are checked. This separates a correct push/pop mapping from a mapping that was swapped or mirrored.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int AW = 32,
  parameter int NR = 16,
  localparam int IW = $clog2(NR),
  localparam int CW = $clog2(NR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [NR-1:0] reg_list,
  input  logic          is_load,
  input  logic [1:0]    addr_mode,
  input  logic          stack_en,
  input  logic [1:0]    stack_kind,
  input  logic          writeback,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [IW-1:0] mem_reg,
  input  logic          mem_ready,
  output logic          done,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t        state;
  logic [NR-1:0] pending;
  logic [AW-1:0] cur_addr, new_base;
  logic          we_q, wb_q;

  logic [1:0]    eff_mode;
  logic [CW-1:0] count;
  logic [AW-1:0] span, first_addr;
  logic [IW-1:0] pick;
  logic          last;

  always_comb begin
    eff_mode = addr_mode;
    if (stack_en) begin
      case ({is_load, stack_kind})
        3'b000: eff_mode = 2'd1;
        3'b001: eff_mode = 2'd3;
        3'b010: eff_mode = 2'd0;
        3'b011: eff_mode = 2'd2;
        3'b100: eff_mode = 2'd2;
        3'b101: eff_mode = 2'd0;
        3'b110: eff_mode = 2'd3;
        default: eff_mode = 2'd1;
      endcase
    end
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < NR; i++) count = count + CW'(reg_list[i]);
  end

  assign span = AW'(count) << 2;

  always_comb begin
    case (eff_mode)
      2'd0: first_addr = base_addr;
      2'd1: first_addr = base_addr + AW'(4);
      2'd2: first_addr = base_addr - span + AW'(4);
      default: first_addr = base_addr - span;
    endcase
  end

  always_comb begin
    pick = '0;
    for (int i = NR - 1; i >= 0; i--) if (pending[i]) pick = IW'(i);
  end

  assign last = (pending & (pending - NR'(1))) == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pending  <= '0;
      cur_addr <= '0;
      new_base <= '0;
      we_q     <= 1'b0;
      wb_q     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          pending  <= reg_list;
          cur_addr <= first_addr;
          new_base <= eff_mode[1] ? base_addr - span : base_addr + span;
          we_q     <= !is_load;
          wb_q     <= writeback;
          state    <= (reg_list == '0) ? S_FIN : S_RUN;
        end
        S_RUN: if (mem_ready) begin
          pending[pick] <= 1'b0;
          cur_addr      <= cur_addr + AW'(4);
          if (last) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = state != S_IDLE;
  assign mem_req  = state == S_RUN;
  assign mem_we   = we_q;
  assign mem_addr = cur_addr;
  assign mem_reg  = pick;
  assign done     = state == S_FIN;
  assign wb_valid = done && wb_q;
  assign wb_addr  = new_base;

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> (!mem_req || mem_addr == $past(mem_addr) + AW'(4)));

  assert_reg_ascend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> (!mem_req || mem_reg > $past(mem_reg)));

  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_reg)));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_wb_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done);

  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && start) |=> $stable(mem_we));

endmodule

// File: tb/blk_xfer_seq_tb.sv
module blk_xfer_seq_tb;
  localparam int AW = 32;
  localparam int NR = 16;

  logic clk = 0, rst_n = 0;
  logic start = 0, is_load = 0, stack_en = 0, writeback = 0, mem_ready = 0;
  logic [AW-1:0] base_addr = '0;
  logic [NR-1:0] reg_list = '0;
  logic [1:0] addr_mode = '0, stack_kind = '0;
  logic busy, mem_req, mem_we, done, wb_valid;
  logic [AW-1:0] mem_addr, wb_addr;
  logic [3:0] mem_reg;

  int vectors = 0, miscompares = 0, cyc = 0;

  always #5 clk = ~clk;

  blk_xfer_seq #(.AW(AW), .NR(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .reg_list(reg_list), .is_load(is_load), .addr_mode(addr_mode),
    .stack_en(stack_en), .stack_kind(stack_kind), .writeback(writeback),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_reg(mem_reg), .mem_ready(mem_ready), .done(done),
    .wb_valid(wb_valid), .wb_addr(wb_addr));

  task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] map_mode(input logic ld, input logic [1:0] kind);
    logic [1:0] push_t [4] = '{2'd1, 2'd3, 2'd0, 2'd2};
    logic [1:0] pop_t  [4] = '{2'd2, 2'd0, 2'd3, 2'd1};
    return ld ? pop_t[kind] : push_t[kind];
  endfunction

  task automatic run(input logic [AW-1:0] base, input logic [NR-1:0] lst, input logic ld,
                     input logic [1:0] md, input logic sten, input logic [1:0] kind,
                     input logic wb, input bit poke, input logic [AW-1:0] wb_fixed,
                     input bit use_fixed);
    logic [1:0] em;
    int n, k;
    int exp_reg [NR];
    logic [AW-1:0] lo, fin;
    string tag;
    bit poked;
    em = sten ? map_mode(ld, kind) : md;
    n = 0;
    for (int i = 0; i < NR; i++) if (lst[i]) begin exp_reg[n] = i; n++; end
    case (em)
      2'd0: lo = base;
      2'd1: lo = base + 4;
      2'd2: lo = base - 4 * n + 4;
      default: lo = base - 4 * n;
    endcase
    fin = em[1] ? base - 4 * n : base + 4 * n;
    tag = em == 0 ? "R1" : em == 1 ? "R2" : em == 2 ? "R3" : "R4";
    if (sten) tag = {tag, ld ? "/R8" : "/R7"};
    if (poke) tag = {tag, "/R11"};
    @(negedge clk);
    start = 1; base_addr = base; reg_list = lst; is_load = ld; addr_mode = md;
    stack_en = sten; stack_kind = kind; writeback = wb; mem_ready = 0;
    @(negedge clk);
    start = 0;
    k = 0; poked = 0;
    for (int g = 0; g < 200; g++) begin
      if (k == n) begin
        chk(done, $sformatf("R12/R9 %s done after last", tag), AW'(done), 1);
        break;
      end
      chk(mem_req && !done, $sformatf("R5 %s req", tag), AW'(mem_req), 1);
      chk(mem_reg == 4'(exp_reg[k]), $sformatf("R5 %s reg k=%0d", tag, k), AW'(mem_reg), AW'(exp_reg[k]));
      chk(mem_addr == lo + 4 * k, $sformatf("%s/R10 addr k=%0d", tag, k), mem_addr, lo + 4 * k);
      chk(mem_we == !ld, $sformatf("R5 %s we", tag), AW'(mem_we), AW'(!ld));
      cyc++;
      mem_ready = ((cyc * 7 + 3) % 5) != 0;
      if (poke && !poked && busy) begin
        start = 1; base_addr = base + 32'h100; reg_list = '1; is_load = !ld;
        addr_mode = md + 2'd1; writeback = !wb; poked = 1;
      end
      if (mem_ready) k++;
      @(negedge clk);
      start = 0;
    end
    mem_ready = 0;
    chk(done, $sformatf("R12 %s done seen", tag), AW'(done), 1);
    chk(wb_valid == wb, $sformatf("R6 %s wb_valid", tag), AW'(wb_valid), AW'(wb));
    if (wb) chk(wb_addr == fin, $sformatf("R6 %s wb_addr", tag), wb_addr, fin);
    if (use_fixed) chk(wb_addr == wb_fixed, $sformatf("R6 %s known base", tag), wb_addr, wb_fixed);
    @(negedge clk);
    chk(!done && !busy && !mem_req, $sformatf("R12 %s single pulse", tag), AW'({done, busy, mem_req}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [NR-1:0] masks [8] = '{16'h0000, 16'h0001, 16'h8000, 16'h000E,
                                 16'hA5A5, 16'h8001, 16'hFFFF, 16'h0F30};
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !done && !wb_valid, "reset state", AW'({busy, mem_req, done, wb_valid}), 0);
    rst_n = 1;
    for (int md = 0; md < 4; md++)
      for (int ld = 0; ld < 2; ld++)
        for (int wb = 0; wb < 2; wb++)
          for (int m = 0; m < 8; m++)
            run(32'h0009_0000 + 32'(m * 64), masks[m], ld[0], md[1:0], 0, 0, wb[0], 0, 0, 0);
    for (int kd = 0; kd < 4; kd++)
      for (int ld = 0; ld < 2; ld++)
        run(32'h0008_0040, 16'h0A12, ld[0], 2'd0, 1, kd[1:0], 1, 0, 0, 0);
    run(32'h0008_0010, 16'h000E, 1, 2'd0, 0, 0, 1, 0, 32'h0008_001C, 1);
    run(32'h0008_0010, 16'h000E, 1, 2'd1, 0, 0, 1, 0, 32'h0008_001C, 1);
    run(32'h0008_0014, 16'h0012, 0, 2'd0, 1, 2'd1, 1, 0, 32'h0008_000C, 1);
    run(32'h0008_0010, 16'h0012, 0, 2'd0, 1, 2'd3, 1, 0, 32'h0008_0008, 1);
    run(32'h0000_9000, 16'h00F0, 1, 2'd2, 0, 0, 1, 1, 0, 0);
    run(32'h0000_9000, 16'h0000, 0, 2'd3, 0, 0, 1, 0, 32'h0000_9000, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule